// File: doc/BRIEF.md
# Reed-Solomon Symbol Correction Applier

This block writes the corrections found by a Reed-Solomon decoder back into a page buffer. The buffer is byte-addressed. It holds 2048 data bytes, and the spare bytes follow at address 2048 onward, so spare byte k sits at address 2048+k. The codeword is a chain of 1367 twelve-bit symbols packed most-significant-bit first into that byte stream. Symbol p starts at bit offset 12p-4. The top four bits of symbol 0 lie before the buffer and are dropped. Symbol 1365 spans the last data byte and the first spare byte.

A job starts with a one-cycle `start_i` that carries the number of errors and the decoder's failure flag. The block then accepts (location, pattern) pairs over a valid/ready handshake. For each pair it works out the one or two bytes the symbol covers. It corrects each byte with a read cycle followed by a write cycle that stores the read value XOR the shifted pattern. When all pairs are applied, or at once on failure or a zero count, it pulses `done_o`. It also presents the number of corrected symbols and an uncorrectable flag.

Top module: `rs_sym_fixer`

## Requirements
- R1: An odd location p changes byte floor(3p/2) by XOR with pattern bits 11:4, then changes the high nibble of byte floor(3p/2)+1 with pattern bits 3:0.
- R2: An even nonzero location p changes the low nibble of byte 3p/2-1 with pattern bits 11:8, then changes byte 3p/2 with pattern bits 7:0.
- R3: Location 0 changes only byte 0, with pattern bits 7:0. Byte 1 is left untouched.
- R4: Location 1365 changes data byte 2047 with pattern bits 11:4 and the high nibble of spare byte 0 (address 2048) with pattern bits 3:0.
- R5: Locations above 1365 follow R1/R2 with spare byte k at address 2048+k. Location 1366 changes the low nibble of address 2048 with bits 11:8 and address 2049 with bits 7:0. No access goes beyond the buffer.
- R6: Every byte update is a read (`mem_rd_o`) in one cycle, followed in the next cycle by a write (`mem_wr_o`) to the same address of read data XOR mask. Read and write are never active together. Updates run in ascending address order, so corrections that hit the same byte accumulate.
- R7: A start with `fail_i`=1 performs no write and never raises `pair_ready_o`. It pulses `done_o` with `uncorr_o`=1 and `fixed_cnt_o`=0.
- R8: After `count_i` pairs have been applied, `done_o` pulses for exactly one cycle with `fixed_cnt_o`=`count_i` and `uncorr_o`=0. Both results hold until the next accepted start.
- R9: A start with `count_i`=0 and no failure pulses `done_o` without any memory access, reporting 0 corrected symbols.
- R10: After reset, `done_o`, `pair_ready_o`, `mem_rd_o`, `mem_wr_o` and `uncorr_o` are 0 and `fixed_cnt_o` is 0.
- R11: `start_i` is ignored while a job is in progress, and `pair_ready_o` is high only while the block waits for the next pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a job (one-cycle pulse) |
| count_i | input | CNT_W | Number of error pairs that follow |
| fail_i | input | 1 | Decoder could not correct the codeword |
| pair_valid_i | input | 1 | Location/pattern pair is valid |
| pair_loc_i | input | LOC_W | Symbol index of the error |
| pair_pat_i | input | 12 | Error pattern of the symbol |
| pair_ready_o | output | 1 | Pair accepted this cycle when valid |
| mem_addr_o | output | ADDR_W | Buffer byte address |
| mem_rd_o | output | 1 | Buffer read strobe, data returned next cycle |
| mem_wr_o | output | 1 | Buffer write strobe |
| mem_wdata_o | output | 8 | Corrected byte to write |
| mem_rdata_i | input | 8 | Byte read from the buffer |
| done_o | output | 1 | Job finished (one-cycle pulse) |
| uncorr_o | output | 1 | Last job was uncorrectable |
| fixed_cnt_o | output | CNT_W | Symbols corrected by the last job |

## Verification
The bench aims at the ends of the symbol chain. Symbol 0 must stay within byte 0; a design that applied its upper nibble would corrupt byte 1 or write out of order. Symbols 1365 and 1366 meet in spare byte 0 and must not wrap into the data area. Adjacent odd/even locations, and a location repeated in one job, share a byte, so a design that computed write data from a stale copy instead of a fresh read would lose one correction. The failure case, a zero count, and a start arriving mid-job show whether a design writes when it must not, hangs waiting for pairs, or restarts on a spurious pulse.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;
  localparam int SYM_W  = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {C_IDLE, C_TAKE, C_WAIT, C_FIN} ctrl_st_e;
  typedef enum logic [2:0] {E_IDLE, E_RD0, E_WR0, E_RD1, E_WR1} rmw_st_e;
endpackage

// File: rtl/rsfix_map.sv
module rsfix_map
  import rsfix_pkg::*;
#(
  parameter int LOC_W  = 11,
  parameter int ADDR_W = 12
) (
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [SYM_W-1:0]  pat_i,
  output logic [ADDR_W-1:0] a0_o,
  output logic [BYTE_W-1:0] m0_o,
  output logic [ADDR_W-1:0] a1_o,
  output logic [BYTE_W-1:0] m1_o,
  output logic              two_o
);
  logic [LOC_W+1:0] prod;
  logic [ADDR_W-1:0] half;

  // floor(3p/2)
  assign prod = {2'b00, loc_i} + {1'b0, loc_i, 1'b0};
  assign half = ADDR_W'(prod[LOC_W+1:1]);

  always_comb begin
    if (loc_i[0]) begin
      a0_o  = half;
      m0_o  = pat_i[11:4];
      a1_o  = half + ADDR_W'(1);
      m1_o  = {pat_i[3:0], 4'h0};
      two_o = 1'b1;
    end else if (loc_i == '0) begin
      // upper nibble of symbol 0 lies before the buffer
      a0_o  = '0;
      m0_o  = pat_i[7:0];
      a1_o  = '0;
      m1_o  = '0;
      two_o = 1'b0;
    end else begin
      a0_o  = half - ADDR_W'(1);
      m0_o  = {4'h0, pat_i[11:8]};
      a1_o  = half;
      m1_o  = pat_i[7:0];
      two_o = 1'b1;
    end
  end
endmodule

// File: rtl/rsfix_rmw.sv
module rsfix_rmw
  import rsfix_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] a0_i,
  input  logic [BYTE_W-1:0] m0_i,
  input  logic [ADDR_W-1:0] a1_i,
  input  logic [BYTE_W-1:0] m1_i,
  input  logic              two_i,
  output logic              ack_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  rmw_st_e           st;
  logic [ADDR_W-1:0] a0_q, a1_q;
  logic [BYTE_W-1:0] m0_q, m1_q;
  logic              two_q;
  logic              second;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= E_IDLE;
      a0_q  <= '0;
      a1_q  <= '0;
      m0_q  <= '0;
      m1_q  <= '0;
      two_q <= 1'b0;
    end else begin
      unique case (st)
        E_IDLE: if (go_i) begin
          a0_q  <= a0_i;
          a1_q  <= a1_i;
          m0_q  <= m0_i;
          m1_q  <= m1_i;
          two_q <= two_i;
          st    <= E_RD0;
        end
        E_RD0:   st <= E_WR0;
        E_WR0:   st <= two_q ? E_RD1 : E_IDLE;
        E_RD1:   st <= E_WR1;
        E_WR1:   st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
    end
  end

  assign second      = (st == E_RD1) || (st == E_WR1);
  assign mem_addr_o  = second ? a1_q : a0_q;
  assign mem_rd_o    = (st == E_RD0) || (st == E_RD1);
  assign mem_wr_o    = (st == E_WR0) || (st == E_WR1);
  assign mem_wdata_o = mem_rdata_i ^ (second ? m1_q : m0_q);
  assign ack_o       = ((st == E_WR0) && !two_q) || (st == E_WR1);
endmodule

// File: rtl/rsfix_ctrl.sv
module rsfix_ctrl
  import rsfix_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             fail_i,
  input  logic             valid_i,
  input  logic             ack_i,
  output logic             ready_o,
  output logic             go_o,
  output logic             done_o,
  output logic             uncorr_o,
  output logic [CNT_W-1:0] fixed_cnt_o
);
  ctrl_st_e         st;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= C_IDLE;
      left        <= '0;
      fixed_cnt_o <= '0;
      uncorr_o    <= 1'b0;
    end else begin
      unique case (st)
        C_IDLE: if (start_i) begin
          left        <= count_i;
          fixed_cnt_o <= '0;
          uncorr_o    <= fail_i;
          st          <= (fail_i || count_i == '0) ? C_FIN : C_TAKE;
        end
        C_TAKE: if (valid_i) st <= C_WAIT;
        C_WAIT: if (ack_i) begin
          fixed_cnt_o <= fixed_cnt_o + CNT_W'(1);
          left        <= left - CNT_W'(1);
          st          <= (left == CNT_W'(1)) ? C_FIN : C_TAKE;
        end
        C_FIN:   st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end

  assign ready_o = (st == C_TAKE);
  assign go_o    = ready_o && valid_i;
  assign done_o  = (st == C_FIN);
endmodule

// File: rtl/rs_sym_fixer.sv
module rs_sym_fixer
  import rsfix_pkg::*;
#(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int NUM_SYM     = 1367,
  parameter int MAX_ERR     = 4,
  localparam int ADDR_W     = $clog2(DATA_BYTES + SPARE_BYTES),
  localparam int LOC_W      = $clog2(NUM_SYM),
  localparam int CNT_W      = $clog2(MAX_ERR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              fail_i,
  input  logic              pair_valid_i,
  input  logic [LOC_W-1:0]  pair_loc_i,
  input  logic [SYM_W-1:0]  pair_pat_i,
  output logic              pair_ready_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              uncorr_o,
  output logic [CNT_W-1:0]  fixed_cnt_o
);
  logic [ADDR_W-1:0] a0, a1;
  logic [BYTE_W-1:0] m0, m1;
  logic              two, go, ack;

  rsfix_map #(.LOC_W(LOC_W), .ADDR_W(ADDR_W)) u_map (
    .loc_i (pair_loc_i),
    .pat_i (pair_pat_i),
    .a0_o  (a0),
    .m0_o  (m0),
    .a1_o  (a1),
    .m1_o  (m1),
    .two_o (two)
  );

  rsfix_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .count_i     (count_i),
    .fail_i      (fail_i),
    .valid_i     (pair_valid_i),
    .ack_i       (ack),
    .ready_o     (pair_ready_o),
    .go_o        (go),
    .done_o      (done_o),
    .uncorr_o    (uncorr_o),
    .fixed_cnt_o (fixed_cnt_o)
  );

  rsfix_rmw #(.ADDR_W(ADDR_W)) u_rmw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .a0_i        (a0),
    .m0_i        (m0),
    .a1_i        (a1),
    .m1_i        (m1),
    .two_i       (two),
    .ack_o       (ack),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );
endmodule

// File: rtl/rs_sym_fixer_chk.sv
module rs_sym_fixer_chk #(
  parameter int ADDR_W      = 12,
  parameter int CNT_W       = 3,
  parameter int TOTAL_BYTES = 2112
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pair_ready_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              done_o,
  input logic              uncorr_o,
  input logic [CNT_W-1:0]  fixed_cnt_o
);
  // R6
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($past(mem_rd_o) && ($past(mem_addr_o) == mem_addr_o)));

  // R6
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  // R5
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> (int'(mem_addr_o) < TOTAL_BYTES));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  uncorr_no_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> ((fixed_cnt_o == '0) && !mem_wr_o));

  // R11
  ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_ready_o |-> (!done_o && !mem_rd_o && !mem_wr_o));
endmodule

bind rs_sym_fixer rs_sym_fixer_chk #(
  .ADDR_W      (ADDR_W),
  .CNT_W       (CNT_W),
  .TOTAL_BYTES (DATA_BYTES + SPARE_BYTES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pair_ready_o (pair_ready_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .done_o       (done_o),
  .uncorr_o     (uncorr_o),
  .fixed_cnt_o  (fixed_cnt_o)
);

// File: tb/rs_sym_fixer_test.sv
module rs_sym_fixer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 2112;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  count_i = '0;
  logic        fail_i = 1'b0;
  logic        pair_valid_i = 1'b0;
  logic [10:0] pair_loc_i = '0;
  logic [11:0] pair_pat_i = '0;
  logic        pair_ready_o;
  logic [11:0] mem_addr_o;
  logic        mem_rd_o, mem_wr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata = '0;
  logic        done_o, uncorr_o;
  logic [2:0]  fixed_cnt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_sym_fixer uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .count_i(count_i),
    .fail_i(fail_i), .pair_valid_i(pair_valid_i), .pair_loc_i(pair_loc_i),
    .pair_pat_i(pair_pat_i), .pair_ready_o(pair_ready_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata), .done_o(done_o),
    .uncorr_o(uncorr_o), .fixed_cnt_o(fixed_cnt_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R10";
  logic [7:0] ram [NBYTES];
  logic [7:0] shadow [NBYTES];
  int exp_addr_q[$];
  int exp_data_q[$];
  int locs[4];
  int pats[4];

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // buffer model: read data one cycle after the strobe
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) ram[i] <= init_val(i);
    end else begin
      if (mem_rd_o) mem_rdata <= ram[mem_addr_o];
      if (mem_wr_o) ram[mem_addr_o] <= mem_wdata_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bit-stream model: symbol p occupies stream bits 12p-4 .. 12p+7, MSB first
  task automatic apply_sym(input int p, input int pat);
    int s, lo, hi, m, pos;
    s  = 12 * p - 4;
    lo = (s < 0) ? 0 : s / 8;
    hi = (s + 11) / 8;
    for (int b = lo; b <= hi; b++) begin
      m = 0;
      for (int k = 0; k < 12; k++) begin
        pos = s + (11 - k);
        if (pos >= 0 && pos / 8 == b && ((pat >> k) & 1) == 1)
          m = m | (1 << (7 - pos % 8));
      end
      shadow[b] = shadow[b] ^ 8'(m);
      exp_addr_q.push_back(b);
      exp_data_q.push_back(int'(shadow[b]));
    end
  endtask

  // scoreboard monitor
  logic        prev_rd = 1'b0;
  logic [11:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr_o) begin
        chk(prev_rd && prev_addr == mem_addr_o, "R6", "write not preceded by read",
            int'(prev_addr), int'(mem_addr_o));
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, cur_req, "unexpected write", int'(mem_addr_o), -1);
        end else begin
          int ea, ed;
          ea = exp_addr_q.pop_front();
          ed = exp_data_q.pop_front();
          chk(int'(mem_addr_o) == ea, cur_req, "write addr", int'(mem_addr_o), ea);
          chk(int'(mem_wdata_o) == ed, cur_req, "write data", int'(mem_wdata_o), ed);
        end
      end
      prev_rd   = mem_rd_o;
      prev_addr = mem_addr_o;
    end
  end

  task automatic run_job(input int n, input bit fl, input string req, input bit poke);
    bit saw_ready;
    int k, mism;
    saw_ready = 1'b0;
    if (!fl) for (int i = 0; i < n; i++) apply_sym(locs[i], pats[i]);
    cur_req = req;
    @(negedge clk);
    start_i = 1'b1; count_i = 3'(n); fail_i = fl;
    @(negedge clk);
    start_i = 1'b0; count_i = '0; fail_i = 1'b0;
    if (!fl) begin
      for (int i = 0; i < n; i++) begin
        pair_valid_i = 1'b1;
        pair_loc_i   = 11'(locs[i]);
        pair_pat_i   = 12'(pats[i]);
        k = 0;
        while (!pair_ready_o && k < 500) begin @(negedge clk); k++; end
        @(negedge clk);
        pair_valid_i = 1'b0;
        if (poke && i == 0) begin
          // R11: spurious start with failure while busy
          start_i = 1'b1; fail_i = 1'b1; count_i = '0;
          @(negedge clk);
          start_i = 1'b0; fail_i = 1'b0;
        end
      end
    end
    k = 0;
    if (pair_ready_o) saw_ready = 1'b1;
    while (!done_o && k < 500) begin
      @(negedge clk); k++;
      if (pair_ready_o) saw_ready = 1'b1;
    end
    chk(done_o == 1'b1, req, "R8 done raised", int'(done_o), 1);
    chk(int'(fixed_cnt_o) == (fl ? 0 : n), req, "R8 corrected count",
        int'(fixed_cnt_o), fl ? 0 : n);
    chk(uncorr_o == fl, req, "R7 uncorrectable flag", int'(uncorr_o), int'(fl));
    if (fl) chk(!saw_ready, req, "R7 ready raised on failure", int'(saw_ready), 0);
    @(negedge clk);
    chk(done_o == 1'b0, req, "R8 done is a pulse", int'(done_o), 0);
    chk(int'(fixed_cnt_o) == (fl ? 0 : n), req, "R8 count held",
        int'(fixed_cnt_o), fl ? 0 : n);
    chk(exp_addr_q.size() == 0, req, "writes missing", exp_addr_q.size(), 0);
    mism = 0;
    for (int b = 0; b < NBYTES; b++) if (ram[b] !== shadow[b]) mism++;
    chk(mism == 0, req, "buffer bytes differing from model", mism, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NBYTES; i++) shadow[i] = init_val(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!done_o && !pair_ready_o, "R10", "done/ready after reset",
        int'({done_o, pair_ready_o}), 0);
    chk(!mem_rd_o && !mem_wr_o, "R10", "mem strobes after reset",
        int'({mem_rd_o, mem_wr_o}), 0);
    chk(!uncorr_o && fixed_cnt_o == '0, "R10", "results after reset",
        int'({uncorr_o, fixed_cnt_o}), 0);

    // R3: symbol 0 touches only byte 0
    locs[0] = 0; pats[0] = 'hF7E;
    run_job(1, 1'b0, "R3", 1'b0);
    chk(ram[1] == init_val(1), "R3", "byte 1 untouched", int'(ram[1]), int'(init_val(1)));

    // R1: odd locations
    locs[0] = 1; pats[0] = 'hABC; locs[1] = 701; pats[1] = 'h123;
    run_job(2, 1'b0, "R1", 1'b0);

    // R2: even locations
    locs[0] = 2; pats[0] = 'h5A3; locs[1] = 1200; pats[1] = 'hFFF;
    run_job(2, 1'b0, "R2", 1'b0);

    // R4: data/spare straddle
    locs[0] = 1365; pats[0] = 'h9D2;
    run_job(1, 1'b0, "R4", 1'b0);

    // R5: spare-area symbols, sharing spare byte 0
    locs[0] = 1366; pats[0] = 'h3C5; locs[1] = 1365; pats[1] = 'h0A7;
    run_job(2, 1'b0, "R5", 1'b0);

    // R6: shared byte and repeated location accumulate
    locs[0] = 3; pats[0] = 'h0F0; locs[1] = 4; pats[1] = 'h00F; locs[2] = 3; pats[2] = 'h111;
    run_job(3, 1'b0, "R6", 1'b0);

    // R8: full job of the maximum count
    locs[0] = 100; pats[0] = 'h801; locs[1] = 683; pats[1] = 'h6E9;
    locs[2] = 1000; pats[2] = 'h24C; locs[3] = 7; pats[3] = 'hFFF;
    run_job(4, 1'b0, "R8", 1'b0);

    // R7: decoder failure
    run_job(3, 1'b1, "R7", 1'b0);

    // R9: zero count
    run_job(0, 1'b0, "R9", 1'b0);

    // R11: start while busy is ignored
    locs[0] = 50; pats[0] = 'hC3A; locs[1] = 51; pats[1] = 'h5E1;
    run_job(2, 1'b0, "R11", 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule